// File: doc/BRIEF.md
# Flash Program/Erase Control Status Register

This block is an 8-bit control and status register. It sits between a byte-wide CPU register bus and the automatic program/erase engine of an embedded flash. Software uses it to arm the flash for programming or erasing, to enable a completion interrupt and to select low-power modes. It also observes a ready flag that tracks the engine and a sticky completion flag that the engine sets when an operation ends.

The block also gates the flash command path. A command write to one of the top two flash banks becomes a one-cycle program/erase strobe only when write enable is set. While the engine is busy, only control-class commands are forwarded; these are the read/reset and the erase-halt commands. The completion flag can only be cleared by writing 0 to it. During a read-modify-write access it reads back as 1, so a bit-set sequence elsewhere in the register cannot wipe out a completion that is still pending.

Top module: `flash_ctl_csr`

## Requirements
- R1: After a synchronous reset, the register reads 0x10 (only the ready bit set), and `irq`, `fl_pe_strobe` and `lp_mode` are all 0.
- R2: A write at address 0x00AE stores bit 7 (interrupt enable), bit 5 (write enable), bit 3 and bit 1 (low-power select). These read back in the same positions, and `lp_mode` shows {bit 3, bit 1}. Read data appears one cycle after the read strobe.
- R3: Bit 4 (ready) reads as the inverse of `eng_busy` as sampled one clock earlier. Writes do not change it.
- R4: A one-cycle `eng_done` pulse sets bit 6 (completion flag), and the flag stays set afterwards.
- R5: Writing bit 6 = 0 clears the completion flag. Writing bit 6 = 1 leaves it unchanged.
- R6: If a write of bit 6 = 0 and an `eng_done` pulse occur in the same cycle, the flag ends up set.
- R7: A read with `reg_rmw` high returns 1 in bit 6, whatever the true value of the flag.
- R8: `irq` is high exactly while interrupt enable and the completion flag are both 1. It updates on the same clock edge as those bits and stays high until software clears one of them.
- R9: Bits 2 and 0 always read 0, whatever value was written.
- R10: `fl_pe_strobe` pulses one cycle after an `fl_wr` whose `fl_bank` is 0xFE or 0xFF, but only if write enable is 1 and ready is 1. No strobe is produced for any other bank, or when write enable is 0.
- R11: While ready is 0, a bank write with `fl_ctl_cmd` = 0 (program/erase) is blocked. A bank write with `fl_ctl_cmd` = 1 (read/reset or erase-halt) is still forwarded when write enable is 1.
- R12: Writes to any other address leave the register unchanged. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register bus byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Qualifies the read as part of a read-modify-write |
| reg_rdata | output | 8 | Registered read data, valid one cycle after `reg_rd` |
| eng_busy | input | 1 | Flash engine operation in progress |
| eng_done | input | 1 | One-cycle end-of-algorithm pulse from the engine |
| fl_wr | input | 1 | CPU write into the flash address space |
| fl_bank | input | 8 | Bank number of that flash write |
| fl_ctl_cmd | input | 1 | 1 = read/reset or erase-halt command, 0 = program/erase |
| fl_pe_strobe | output | 1 | Registered program/erase command strobe to the flash |
| irq | output | 1 | Registered completion interrupt request (level) |
| lp_mode | output | 2 | Low-power select {bit 3, bit 1} |

## Verification
Some properties are checked on every cycle. The interrupt level always equals the AND of the enable and completion bits. Each engine completion pulse sets the flag, and the ready bit follows the engine's busy line. Reserved read positions stay zero, a read-modify-write read shows the flag as 1, and no strobe appears unless write enable was set. Other behaviour can only be shown by the bench's scenarios: the full sweep of write values against readback, the sweep over bank number, write enable, ready and command class for the command gate, the write-1-ignored and same-cycle-priority cases for the flag, and the isolation of other addresses.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;
  localparam int CSR_W   = 8;
  localparam int BIT_IE  = 7;
  localparam int BIT_CF  = 6;
  localparam int BIT_WEN = 5;
  localparam int BIT_RDY = 4;
  localparam int BIT_LP1 = 3;
  localparam int BIT_LP0 = 1;
  localparam int LP_W    = 2;
endpackage

// File: rtl/fcsr_regs.sv
module fcsr_regs
  import flash_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CSR_W-1:0] wdata,
  input  logic             eng_done,
  input  logic             eng_busy,
  output logic             ie_q,
  output logic             cf_q,
  output logic             wen_q,
  output logic             ready_q,
  output logic [LP_W-1:0]  lp_q,
  output logic             irq_q
);
  logic ie_n;
  logic cf_n;

  // completion set outranks a software clear in the same cycle
  always_comb begin
    ie_n = wr_hit ? wdata[BIT_IE] : ie_q;
    if (eng_done)
      cf_n = 1'b1;
    else if (wr_hit && !wdata[BIT_CF])
      cf_n = 1'b0;
    else
      cf_n = cf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      cf_q    <= 1'b0;
      wen_q   <= 1'b0;
      ready_q <= 1'b1;
      lp_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      ie_q    <= ie_n;
      cf_q    <= cf_n;
      ready_q <= !eng_busy;
      irq_q   <= ie_n && cf_n;
      if (wr_hit) begin
        wen_q <= wdata[BIT_WEN];
        lp_q  <= {wdata[BIT_LP1], wdata[BIT_LP0]};
      end
    end
  end
endmodule

// File: rtl/fcsr_gate.sv
module fcsr_gate #(
  parameter int                BANK_W  = 8,
  parameter logic [BANK_W-1:0] BANK_LO = 8'hFE,
  parameter logic [BANK_W-1:0] BANK_HI = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fl_wr,
  input  logic [BANK_W-1:0] fl_bank,
  input  logic              fl_ctl_cmd,
  input  logic              wen,
  input  logic              ready,
  output logic              strobe_q
);
  localparam logic [BANK_W-1:0] BANK_TOP = '1;
  logic bank_hit;

  generate
    if (BANK_LO == BANK_HI) begin : g_single
      assign bank_hit = (fl_bank == BANK_LO);
    end else if (BANK_HI == BANK_TOP) begin : g_upper
      assign bank_hit = (fl_bank >= BANK_LO);
    end else begin : g_range
      assign bank_hit = (fl_bank >= BANK_LO) && (fl_bank <= BANK_HI);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      strobe_q <= 1'b0;
    else
      strobe_q <= fl_wr && bank_hit && wen && (ready || fl_ctl_cmd);
  end
endmodule

// File: rtl/fcsr_rdmux.sv
module fcsr_rdmux
  import flash_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic             rmw,
  input  logic             ie,
  input  logic             cf,
  input  logic             wen,
  input  logic             ready,
  input  logic [LP_W-1:0]  lp,
  output logic [CSR_W-1:0] rdata_q
);
  logic [CSR_W-1:0] image;

  always_comb begin
    image          = '0;
    image[BIT_IE]  = ie;
    image[BIT_CF]  = cf || rmw;
    image[BIT_WEN] = wen;
    image[BIT_RDY] = ready;
    image[BIT_LP1] = lp[1];
    image[BIT_LP0] = lp[0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= rd_hit ? image : '0;
  end
endmodule

// File: rtl/flash_ctl_csr.sv
module flash_ctl_csr
  import flash_csr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 16'h00AE,
  parameter int                BANK_W   = 8,
  parameter logic [BANK_W-1:0] BANK_LO  = 8'hFE,
  parameter logic [BANK_W-1:0] BANK_HI  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  input  logic              reg_rmw,
  output logic [7:0]        reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              fl_wr,
  input  logic [BANK_W-1:0] fl_bank,
  input  logic              fl_ctl_cmd,
  output logic              fl_pe_strobe,
  output logic              irq,
  output logic [1:0]        lp_mode
);
  logic addr_hit;
  logic wr_hit;
  logic rd_hit;
  logic ie_q;
  logic cf_q;
  logic wen_q;
  logic ready_q;
  logic [LP_W-1:0] lp_q;

  assign addr_hit = (reg_addr == CSR_ADDR);
  assign wr_hit   = reg_wr && addr_hit;
  assign rd_hit   = reg_rd && addr_hit;
  assign lp_mode  = lp_q;

  fcsr_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .wdata    (reg_wdata),
    .eng_done (eng_done),
    .eng_busy (eng_busy),
    .ie_q     (ie_q),
    .cf_q     (cf_q),
    .wen_q    (wen_q),
    .ready_q  (ready_q),
    .lp_q     (lp_q),
    .irq_q    (irq)
  );

  fcsr_gate #(
    .BANK_W  (BANK_W),
    .BANK_LO (BANK_LO),
    .BANK_HI (BANK_HI)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .fl_wr      (fl_wr),
    .fl_bank    (fl_bank),
    .fl_ctl_cmd (fl_ctl_cmd),
    .wen        (wen_q),
    .ready      (ready_q),
    .strobe_q   (fl_pe_strobe)
  );

  fcsr_rdmux u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .rmw     (reg_rmw),
    .ie      (ie_q),
    .cf      (cf_q),
    .wen     (wen_q),
    .ready   (ready_q),
    .lp      (lp_q),
    .rdata_q (reg_rdata)
  );
endmodule

// File: rtl/fcsr_chk.sv
module fcsr_chk (
  input logic       clk,
  input logic       rst,
  input logic       eng_done,
  input logic       eng_busy,
  input logic       rd_hit,
  input logic       reg_rmw,
  input logic [7:0] reg_rdata,
  input logic       ie_q,
  input logic       cf_q,
  input logic       wen_q,
  input logic       ready_q,
  input logic       irq,
  input logic       fl_pe_strobe
);
  // R4
  cf_set_chk: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> cf_q);
  // R3
  ready_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ready_q == !$past(eng_busy)));
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ie_q && cf_q));
  // R7
  rmw_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && reg_rmw) |=> reg_rdata[6]);
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[2] == 1'b0) && (reg_rdata[0] == 1'b0));
  // R10
  strobe_wen_chk: assert property (@(posedge clk) disable iff (rst)
    fl_pe_strobe |-> $past(wen_q));
endmodule

bind flash_ctl_csr fcsr_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .eng_done     (eng_done),
  .eng_busy     (eng_busy),
  .rd_hit       (rd_hit),
  .reg_rmw      (reg_rmw),
  .reg_rdata    (reg_rdata),
  .ie_q         (ie_q),
  .cf_q         (cf_q),
  .wen_q        (wen_q),
  .ready_q      (ready_q),
  .irq          (irq),
  .fl_pe_strobe (fl_pe_strobe)
);

// File: tb/flash_ctl_csr_tb.sv
`timescale 1ns/1ps
module flash_ctl_csr_tb;
  localparam logic [15:0] CSR = 16'h00AE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic        reg_rmw = 1'b0;
  logic [7:0]  reg_rdata;
  logic        eng_busy = 1'b0;
  logic        eng_done = 1'b0;
  logic        fl_wr = 1'b0;
  logic [7:0]  fl_bank = '0;
  logic        fl_ctl_cmd = 1'b0;
  logic        fl_pe_strobe;
  logic        irq;
  logic [1:0]  lp_mode;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_ctl_csr u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rmw(reg_rmw),
    .reg_rdata(reg_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
    .fl_wr(fl_wr), .fl_bank(fl_bank), .fl_ctl_cmd(fl_ctl_cmd),
    .fl_pe_strobe(fl_pe_strobe), .irq(irq), .lp_mode(lp_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic rmw, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rmw = rmw; reg_rd = 1'b1;
    @(negedge clk);
    v = reg_rdata;
    reg_rd = 1'b0; reg_rmw = 1'b0; reg_addr = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic bank_cmd(input logic [7:0] b, input logic ctl, output logic s);
    @(negedge clk);
    fl_wr = 1'b1; fl_bank = b; fl_ctl_cmd = ctl;
    @(negedge clk);
    s = fl_pe_strobe;
    fl_wr = 1'b0; fl_ctl_cmd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 strobe", {7'd0, fl_pe_strobe}, 8'h00);
    chk("R1 lp_mode", {6'd0, lp_mode}, 8'h00);
    rd(CSR, 1'b0, v);
    chk("R1 reset value", v, 8'h10);

    // R2 R3 R5 R9: every write value, completion flag starts 0
    for (int i = 0; i < 256; i++) begin
      wr(CSR, 8'(i));
      chk("R2 lp_mode", {6'd0, lp_mode}, {6'd0, 1'(i >> 3), 1'(i >> 1)});
      rd(CSR, 1'b0, v);
      chk("R2/R3/R5/R9 readback", v, (8'(i) & 8'hAA) | 8'h10);
    end

    // R3 ready follows busy
    wr(CSR, 8'h00);
    @(negedge clk); eng_busy = 1'b1;
    @(negedge clk);
    rd(CSR, 1'b0, v);
    chk("R3 busy reads ready 0", v, 8'h00);
    wr(CSR, 8'h10);
    rd(CSR, 1'b0, v);
    chk("R3 write of ready ignored", v, 8'h00);
    @(negedge clk); eng_busy = 1'b0;
    @(negedge clk);
    rd(CSR, 1'b0, v);
    chk("R3 idle reads ready 1", v, 8'h10);

    // R4 R5 R8 with and without interrupt enable
    for (int e = 0; e < 2; e++) begin
      wr(CSR, {1'(e), 7'd0});
      done_pulse();
      chk("R8 irq after done", {7'd0, irq}, {7'd0, 1'(e)});
      repeat (5) @(negedge clk);
      chk("R8 irq level held", {7'd0, irq}, {7'd0, 1'(e)});
      rd(CSR, 1'b0, v);
      chk("R4 flag set", v, {1'(e), 7'h50});
      wr(CSR, {1'(e), 7'h40});
      rd(CSR, 1'b0, v);
      chk("R5 write 1 ignored", v, {1'(e), 7'h50});
      wr(CSR, {1'(e), 7'h00});
      chk("R8 irq drops on clear", {7'd0, irq}, 8'h00);
      rd(CSR, 1'b0, v);
      chk("R5 write 0 clears", v, {1'(e), 7'h10});
    end

    // R8 disabling the enable drops irq while flag stays
    wr(CSR, 8'h80);
    done_pulse();
    chk("R8 irq set", {7'd0, irq}, 8'h01);
    wr(CSR, 8'h40);
    chk("R8 irq drops on enable clear", {7'd0, irq}, 8'h00);
    rd(CSR, 1'b0, v);
    chk("R8 flag kept", v, 8'h50);

    // R6 same-cycle set beats clear
    wr(CSR, 8'h80);
    @(negedge clk);
    eng_done = 1'b1; reg_addr = CSR; reg_wdata = 8'h80; reg_wr = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    chk("R6 irq", {7'd0, irq}, 8'h01);
    rd(CSR, 1'b0, v);
    chk("R6 flag survives", v, 8'hD0);

    // R7 rmw read shows flag 1
    wr(CSR, 8'h00);
    rd(CSR, 1'b1, v);
    chk("R7 rmw read", v, 8'h50);
    rd(CSR, 1'b0, v);
    chk("R7 plain read", v, 8'h10);

    // R12 other addresses
    wr(16'h00AF, 8'hFF);
    wr(16'h00AE ^ 16'h0100, 8'hFF);
    rd(CSR, 1'b0, v);
    chk("R12 no write elsewhere", v, 8'h10);
    rd(16'h00AF, 1'b0, v);
    chk("R12 read elsewhere", v, 8'h00);
    rd(16'h00AF, 1'b1, v);
    chk("R12 rmw read elsewhere", v, 8'h00);

    // R10 R11 sweep: write enable x ready x command class x bank
    for (int w = 0; w < 2; w++) begin
      for (int r = 0; r < 2; r++) begin
        wr(CSR, {2'b00, 1'(w), 5'd0});
        @(negedge clk); eng_busy = (r == 0);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
          for (int b = 0; b < 256; b++) begin
            bank_cmd(8'(b), 1'(c), s);
            chk(r == 1 ? "R10 strobe gate" : "R11 busy gate", {7'd0, s},
                {7'd0, 1'((b >= 254) && (w == 1) && (r == 1 || c == 1))});
          end
        end
      end
    end
    @(negedge clk); eng_busy = 1'b0;
    @(negedge clk);
    chk("R10 strobe one cycle", {7'd0, fl_pe_strobe}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule